// File: doc/BRIEF.md
# Transmit FIFO Low-Watermark Refill Controller

This controller sits beside a transmit block FIFO built as a ring of `NUM_BLK` linked blocks. A DMA engine writes whole blocks into the FIFO and may mark a block as holding a frame end. An HDLC engine drains the FIFO one block at a time. The controller tracks how many blocks are held and how many frame ends are still waiting. It decides two things: when to ask the DMA for a refill, and when the HDLC engine may read.

The refill decision is made in blocks, not bytes. The controller counts the blocks consumed since the last refill. Once enough blocks are gone that only `lowmark` blocks are left, it raises a level request. That request stays high until the FIFO reports full, so every refill tops the ring up completely, even across several packet ends.

Read permission is handled by a second state machine. After the FIFO has drained to empty at a packet end, the reader is held back. It is released only once occupancy rises above `lowmark` or a frame end has been written. Once released, it stays released until the frame end of that packet has been consumed.

Top module: `tx_lowmark_ctrl`

States and transitions:
- Refill machine:
  - `RF_COUNT` goes to `RF_FILL` on the accepted read that brings the consumed count to `NUM_BLK - lowmark`.
  - `RF_FILL` goes back to `RF_COUNT` once the occupancy register shows full, and the consumed count is cleared at that point.
- Read gate:
  - `GT_HOLD` goes to `GT_OPEN` when registered occupancy is above `lowmark`, or when at least one written frame end is pending.
  - `GT_OPEN` goes back to `GT_HOLD` when an accepted read carries a frame end and leaves the FIFO empty.

## Requirements
- R1: After a synchronous active-high reset, the outputs are as follows: `refill_req`=0, `rd_enable`=0, `occupancy`=0 and `cfg_err`=0. Both machines start in their first state.
- R2: `occupancy` changes on the edge after each accepted block write or block read. A write is accepted only while occupancy is below `NUM_BLK`. A read is accepted only while `rd_enable`=1 and occupancy is above 0. A write attempted while full leaves occupancy at `NUM_BLK`.
- R3: While no refill is active, `refill_req` rises on the edge after the accepted read that makes `NUM_BLK - lowmark` consumed blocks in a row. With `NUM_BLK`=5 and `lowmark`=2, this is the third read, which leaves 2 blocks.
- R4: `refill_req` is a level signal. It stays 1 until the cycle after `occupancy` shows `NUM_BLK`, then falls to 0.
- R5: Reads made during a refill do not start a new count. After a refill ends, another `NUM_BLK - lowmark` accepted reads are needed before the next request.
- R6: `lowmark` is legal from 1 to `NUM_BLK-2`. An illegal value sets `cfg_err` on the next edge. `cfg_err` stays set until reset, and while it is set no threshold request is raised.
- R7: While the gate is held, `rd_enable` rises one edge after the occupancy register holds a value above `lowmark`.
- R8: While the gate is held, a written frame-end block opens the gate one edge after it is counted, even when occupancy is at or below `lowmark`.
- R9: Once open, the gate stays open even when occupancy reaches 0. It closes on the edge of an accepted read flagged `rd_eof` that leaves the FIFO empty. A frame-end read that leaves blocks behind keeps the gate open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lowmark | input | CNT_W | Low watermark in blocks |
| blk_wr | input | 1 | DMA completes one block write (one-cycle strobe) |
| wr_eof | input | 1 | The written block holds a frame end |
| blk_rd | input | 1 | HDLC engine consumes one block (one-cycle strobe) |
| rd_eof | input | 1 | The consumed block holds a frame end |
| refill_req | output | 1 | Level request to the DMA to refill until full |
| rd_enable | output | 1 | HDLC engine may read blocks |
| occupancy | output | CNT_W | Blocks currently held |
| cfg_err | output | 1 | Sticky illegal-watermark flag |

## Verification
The embedded properties assume the following about the inputs:
- `blk_wr` and `blk_rd` are per-block strobes.
- `rd_eof` is asserted only on a block that the DMA marked as a frame end.
- `lowmark` changes only by deliberate reprogramming.

The random stimulus keeps within these limits. It draws `rd_eof` only while the bench's own count of pending frame ends is non-zero, and it keeps `lowmark` in the legal range during random traffic. Illegal values are applied only in a directed sequence, which then checks that no request follows.

// File: rtl/tlw_pkg.sv
package tlw_pkg;
    typedef enum logic {
        RF_COUNT = 1'b0,
        RF_FILL  = 1'b1
    } refill_st_t;

    typedef enum logic {
        GT_HOLD = 1'b0,
        GT_OPEN = 1'b1
    } gate_st_t;
endpackage

// File: rtl/tlw_occ_track.sv
module tlw_occ_track #(
    parameter int NUM_BLK = 5,
    parameter int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_wr,
    input  logic             wr_eof,
    input  logic             blk_rd,
    input  logic             rd_eof,
    input  logic             rd_enable,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] occ_nxt,
    output logic [CNT_W-1:0] eof_pend,
    output logic             rd_acc
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BLK);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic wr_acc;
    logic eof_inc;
    logic eof_dec;

    always_comb begin
        wr_acc  = blk_wr && (occ != FULL);
        rd_acc  = blk_rd && rd_enable && (occ != '0);
        eof_inc = wr_acc && wr_eof;
        eof_dec = rd_acc && rd_eof && (eof_pend != '0);
        occ_nxt = occ;
        if (wr_acc && !rd_acc) begin
            occ_nxt = occ + ONE;
        end else if (!wr_acc && rd_acc) begin
            occ_nxt = occ - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ      <= '0;
            eof_pend <= '0;
        end else begin
            occ <= occ_nxt;
            if (eof_inc && !eof_dec) begin
                eof_pend <= eof_pend + ONE;
            end else if (!eof_inc && eof_dec) begin
                eof_pend <= eof_pend - ONE;
            end
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL);                                                   // R2
    AST_OCC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!blk_wr && !blk_rd) |=> $stable(occ));                         // R2
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL && !blk_rd) |=> occ == FULL);                      // R2
endmodule

// File: rtl/tlw_cfg_check.sv
module tlw_cfg_check #(
    parameter int NUM_BLK = 5,
    parameter int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] lowmark,
    output logic             lw_ok,
    output logic             cfg_err
);
    localparam logic [CNT_W-1:0] LW_MIN = CNT_W'(1);
    localparam logic [CNT_W-1:0] LW_MAX = CNT_W'(NUM_BLK - 2);

    always_comb begin
        lw_ok = (lowmark >= LW_MIN) && (lowmark <= LW_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err <= 1'b0;
        end else if (!lw_ok) begin
            cfg_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);                                           // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> ($past(lowmark) < LW_MIN || $past(lowmark) > LW_MAX)); // R6
endmodule

// File: rtl/tlw_refill_fsm.sv
module tlw_refill_fsm
    import tlw_pkg::*;
#(
    parameter int NUM_BLK = 5,
    parameter int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_acc,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] lowmark,
    input  logic             lw_ok,
    input  logic             cfg_err,
    output logic             refill_req
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BLK);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    refill_st_t       st;
    refill_st_t       st_nxt;
    logic [CNT_W-1:0] used_cnt;
    logic [CNT_W:0]   used_inc;
    logic [CNT_W:0]   trig_at;
    logic             hit;

    always_comb begin
        used_inc = {1'b0, used_cnt} + {1'b0, ONE};
        trig_at  = {1'b0, FULL} - {1'b0, lowmark};
        hit      = rd_acc && lw_ok && !cfg_err && (used_inc >= trig_at);
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            RF_COUNT: if (hit)          st_nxt = RF_FILL;
            RF_FILL:  if (occ == FULL)  st_nxt = RF_COUNT;
            default:                    st_nxt = RF_COUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= RF_COUNT;
        end else begin
            st <= st_nxt;
        end
    end

    // consumed-block counter
    always_ff @(posedge clk) begin
        if (rst) begin
            used_cnt <= '0;
        end else if (st == RF_FILL) begin
            if (occ == FULL) begin
                used_cnt <= '0;
            end
        end else if (rd_acc && used_cnt != FULL) begin
            used_cnt <= used_cnt + ONE;
        end
    end

    // outputs
    always_comb begin
        refill_req = (st == RF_FILL);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (refill_req && occ != FULL) |=> refill_req);                    // R4
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (refill_req && occ == FULL) |=> !refill_req);                   // R4
    AST_REQ_ON_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(refill_req) |-> $past(rd_acc));                           // R3
    AST_NO_REQ_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(refill_req) |-> !$past(cfg_err));                         // R6
endmodule

// File: rtl/tlw_read_gate.sv
module tlw_read_gate
    import tlw_pkg::*;
#(
    parameter int NUM_BLK = 5,
    parameter int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_acc,
    input  logic             rd_eof,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] occ_nxt,
    input  logic [CNT_W-1:0] eof_pend,
    input  logic [CNT_W-1:0] lowmark,
    output logic             rd_enable
);
    gate_st_t st;
    gate_st_t st_nxt;

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            GT_HOLD: if (occ > lowmark || eof_pend != '0)       st_nxt = GT_OPEN;
            GT_OPEN: if (rd_acc && rd_eof && occ_nxt == '0)     st_nxt = GT_HOLD;
            default:                                            st_nxt = GT_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= GT_HOLD;
        end else begin
            st <= st_nxt;
        end
    end

    // outputs
    always_comb begin
        rd_enable = (st == GT_OPEN);
    end

    AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_enable) |-> ($past(occ) > $past(lowmark) || $past(eof_pend) != '0)); // R7 R8
    AST_CLOSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_enable) |-> $past(rd_acc && rd_eof));                 // R9
    AST_CLOSE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_enable) |-> occ == '0);                                // R9
endmodule

// File: rtl/tx_lowmark_ctrl.sv
module tx_lowmark_ctrl #(
    parameter int NUM_BLK = 5,
    parameter int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] lowmark,
    input  logic             blk_wr,
    input  logic             wr_eof,
    input  logic             blk_rd,
    input  logic             rd_eof,
    output logic             refill_req,
    output logic             rd_enable,
    output logic [CNT_W-1:0] occupancy,
    output logic             cfg_err
);
    logic [CNT_W-1:0] occ_nxt;
    logic [CNT_W-1:0] eof_pend;
    logic             rd_acc;
    logic             lw_ok;

    tlw_occ_track #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W)) u_occ (
        .clk       (clk),
        .rst       (rst),
        .blk_wr    (blk_wr),
        .wr_eof    (wr_eof),
        .blk_rd    (blk_rd),
        .rd_eof    (rd_eof),
        .rd_enable (rd_enable),
        .occ       (occupancy),
        .occ_nxt   (occ_nxt),
        .eof_pend  (eof_pend),
        .rd_acc    (rd_acc)
    );

    tlw_cfg_check #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .lowmark (lowmark),
        .lw_ok   (lw_ok),
        .cfg_err (cfg_err)
    );

    tlw_refill_fsm #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W)) u_refill (
        .clk        (clk),
        .rst        (rst),
        .rd_acc     (rd_acc),
        .occ        (occupancy),
        .lowmark    (lowmark),
        .lw_ok      (lw_ok),
        .cfg_err    (cfg_err),
        .refill_req (refill_req)
    );

    tlw_read_gate #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .rd_acc    (rd_acc),
        .rd_eof    (rd_eof),
        .occ       (occupancy),
        .occ_nxt   (occ_nxt),
        .eof_pend  (eof_pend),
        .lowmark   (lowmark),
        .rd_enable (rd_enable)
    );

    AST_NO_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (!rd_enable && blk_rd && !blk_wr) |=> $stable(occupancy));      // R2
endmodule

// File: tb/tx_lowmark_ctrl_test.sv
module tx_lowmark_ctrl_test;
    localparam int N = 5;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] lowmark = W'(2);
    logic         blk_wr = 1'b0;
    logic         wr_eof = 1'b0;
    logic         blk_rd = 1'b0;
    logic         rd_eof = 1'b0;
    logic         refill_req;
    logic         rd_enable;
    logic [W-1:0] occupancy;
    logic         cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    int m_occ, m_eof, m_cons, m_req, m_open, m_err;

    always #4 clk = ~clk;

    tx_lowmark_ctrl #(.NUM_BLK(N), .CNT_W(W)) uut (
        .clk(clk), .rst(rst), .lowmark(lowmark),
        .blk_wr(blk_wr), .wr_eof(wr_eof), .blk_rd(blk_rd), .rd_eof(rd_eof),
        .refill_req(refill_req), .rd_enable(rd_enable),
        .occupancy(occupancy), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit lw_legal(input int lw);
        return (lw >= 1) && (lw <= N - 2);
    endfunction

    function automatic int next_occ(input int occ, input bit wa, input bit ra);
        return occ + int'(wa) - int'(ra);
    endfunction

    task automatic model_step(input bit wr, input bit weof, input bit rd, input bit reof);
        int lw, n_occ, n_eof, n_cons, n_req, n_open, n_err;
        bit ra, wa;
        lw     = int'(lowmark);
        ra     = rd && (m_open != 0) && (m_occ > 0);
        wa     = wr && (m_occ < N);
        n_occ  = next_occ(m_occ, wa, ra);
        n_eof  = m_eof + int'(wa && weof) - int'(ra && reof && m_eof > 0);
        n_err  = (m_err != 0 || !lw_legal(lw)) ? 1 : 0;
        n_req  = m_req;
        n_cons = m_cons;
        if (m_req == 0) begin
            if (ra) begin
                if (lw_legal(lw) && m_err == 0 && m_cons + 1 >= N - lw) n_req = 1;
                if (m_cons < N) n_cons = m_cons + 1;
            end
        end else if (m_occ == N) begin
            n_req  = 0;
            n_cons = 0;
        end
        n_open = m_open;
        if (m_open == 0) begin
            if (m_occ > lw || m_eof > 0) n_open = 1;
        end else if (ra && reof && n_occ == 0) begin
            n_open = 0;
        end
        m_occ = n_occ; m_eof = n_eof; m_cons = n_cons;
        m_req = n_req; m_open = n_open; m_err = n_err;
    endtask

    task automatic compare_all();
        chk("R2", "occupancy",  int'(occupancy),  m_occ);
        chk("R4", "refill_req", int'(refill_req), m_req);
        chk("R7", "rd_enable",  int'(rd_enable),  m_open);
        chk("R6", "cfg_err",    int'(cfg_err),    m_err);
    endtask

    task automatic step(input bit wr, input bit weof, input bit rd, input bit reof);
        @(negedge clk);
        blk_wr = wr; wr_eof = weof; blk_rd = rd; rd_eof = reof;
        @(posedge clk);
        model_step(wr, weof, rd, reof);
        #1;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; blk_wr = 0; wr_eof = 0; blk_rd = 0; rd_eof = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_occ = 0; m_eof = 0; m_cons = 0; m_req = 0; m_open = 0; m_err = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        lowmark = W'(2);
        do_reset();
        // R1 reset state
        chk("R1", "refill_req", int'(refill_req), 0);
        chk("R1", "rd_enable",  int'(rd_enable),  0);
        chk("R1", "occupancy",  int'(occupancy),  0);
        chk("R1", "cfg_err",    int'(cfg_err),    0);

        // R7: gate held until occupancy exceeds the watermark
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        chk("R2", "read while gate held", int'(occupancy), 2);
        step(1, 0, 0, 0);
        chk("R7", "gate still held at occ 3", int'(rd_enable), 0);
        step(0, 0, 0, 0);
        chk("R7", "gate opens after occ>lowmark", int'(rd_enable), 1);
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
        chk("R2", "write ignored when full", int'(occupancy), 5);

        // R3: request after three consecutive reads
        step(0, 0, 1, 0); step(0, 0, 1, 0);
        chk("R3", "no request after two reads", int'(refill_req), 0);
        step(0, 0, 1, 0);
        chk("R3", "request after third read", int'(refill_req), 1);
        // R4: held during refill until full is seen
        step(1, 0, 0, 0); step(0, 0, 1, 0);
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
        chk("R4", "held in the cycle occ turns full", int'(refill_req), 1);
        step(0, 0, 0, 0);
        chk("R4", "released after full", int'(refill_req), 0);
        // R5: another full count needed
        step(0, 0, 1, 0); step(0, 0, 1, 0);
        chk("R5", "no request after two reads post refill", int'(refill_req), 0);
        step(0, 0, 1, 0);
        chk("R5", "request after third read post refill", int'(refill_req), 1);

        // R8 / R9: frame end opens and closes the gate
        do_reset();
        step(1, 1, 0, 0);
        step(0, 0, 0, 0);
        chk("R8", "frame end opens gate at occ 1", int'(rd_enable), 1);
        step(0, 0, 1, 1);
        chk("R9", "gate closes on last frame end", int'(rd_enable), 0);
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 0);
        step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0);
        chk("R9", "gate stays open at empty without frame end", int'(rd_enable), 1);

        // R6: illegal watermark
        do_reset();
        lowmark = W'(4);
        step(0, 0, 0, 0);
        chk("R6", "error flag set", int'(cfg_err), 1);
        lowmark = W'(2);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0);
        chk("R6", "error flag sticky", int'(cfg_err), 1);
        chk("R6", "no request while error", int'(refill_req), 0);

        // random traffic with legal watermarks
        for (int blk = 0; blk < 6; blk++) begin
            lowmark = W'(1 + ($urandom % (N - 2)));
            do_reset();
            for (int c = 0; c < 600; c++) begin
                bit wr, weof, rd, reof;
                wr   = (m_req != 0) ? ($urandom % 4 != 0) : ($urandom % 10 < 3);
                weof = ($urandom % 4 == 0);
                rd   = ($urandom % 2 == 0);
                reof = (m_eof > 0) && ($urandom % 2 == 0);
                step(wr, weof, rd, reof);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule